// File: doc/BRIEF.md
# Halfword Host Port to Internal Word Memory

This block is a slave port. An external host uses it to reach a 32-bit word memory inside the block through a 16-bit data path. The host can reach three registers: a control word, an address word and a data word. It picks one of them with a two-bit select code. Each 32-bit value moves as two 16-bit halves, and a half-select pin says which half is on the bus. All host pins are taken as synchronous to `clk`.

An internal active-low strobe is formed from a chip select and two data strobes. The strobe is active when the chip select is low and the two data strobes differ, so either data strobe can start an access. The block latches the select code, the half-select and the direction when the strobe falls. It takes write data when the strobe rises.

A ready output tells the host to wait while a memory word is being fetched into the data register. There are two data-register codes. One keeps the address fixed. The other advances the address after each full word and, on reads, fetches the next word at once. Bit 0 of the control register drives the host interrupt output.

Top module: `hpiTarget`

## Requirements
- R1: The internal strobe is active only while `hcsN` is 0 and `hds1` differs from `hds2`. Toggling the data strobes while `hcsN` is 1, or toggling both together, starts no access. Either data strobe alone can drive an access.
- R2: The select code `hcntl`, the half-select `hhwil` and the direction `hrw` (1 = read) are taken on the falling edge of the internal strobe. Changes to them before the rising edge have no effect on that access.
- R3: Write data on `hdIn` is taken on the rising edge of the internal strobe, so the value present at release is the value stored.
- R4: `hcntl` encoding: 00 selects control, 01 selects data with auto-increment, 10 selects address, 11 selects data with a fixed address. `hhwil` = 0 carries bits 15:0 and `hhwil` = 1 carries bits 31:16 of the selected register, both on writes and on reads.
- R5: A data-register write changes memory only when its second half (`hhwil` = 1) completes. The full word then goes to the memory word at the current address. A first half alone leaves memory unchanged.
- R6: With code 01, each completed word write advances the address register by exactly one. With code 11 the address does not change.
- R7: When `hcsN` falls while `hcntl` is 01 or 11 and `hrw` is 1, `hostReady` drops to 0 for exactly two clock cycles. It then returns to 1 with the memory word at the current address loaded into the data register.
- R8: The second half (`hhwil` = 1) of any access never sees `hostReady` at 0.
- R9: With code 01 on reads, `hostReady` drops to 0 right after the second half completes. The address advances by one and the next word is prefetched, so successive word reads return successive memory words.
- R10: Read data on `hdOut` is driven with `hdOe` high while the strobe is active. After release, both `hdOe` and the `hdOut` value are kept for `HOLD_CYC`-1 further cycles (2 with defaults). After that, `hdOe` is 0.
- R11: `hostInt` always equals bit 0 of the control register.
- R12: After reset, `hostReady` is 1, `hdOe` is 0, `hostInt` is 0, and the control and address registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hcsN | input | 1 | Host chip select, active low |
| hds1 | input | 1 | Host data strobe one |
| hds2 | input | 1 | Host data strobe two |
| hcntl | input | 2 | Register select code |
| hhwil | input | 1 | Half select, 0 = first (low) half, 1 = second (high) half |
| hrw | input | 1 | Direction, 1 = read, 0 = write |
| hdIn | input | 16 | Host write data |
| hdOut | output | 16 | Read data toward the host |
| hdOe | output | 1 | Read data drive enable |
| hostReady | output | 1 | 1 = ready, 0 = host must wait |
| hostInt | output | 1 | Host interrupt, control bit 0 |

## Verification
The bench moves words through every select code in both directions and checks that the halves line up. It then runs three kinds of memory traffic. Fixed-address word writes and reads show that the address is left alone. A lone first-half write separates a committed word from a half-written one. Auto-increment bursts of writes and then reads show that each word lands at the next address and that the prefetch returns the right neighbour. A chip-select fall with a read code present is timed to show the exact two-cycle wait. Strobes that change the select, direction or data between fall and release show which edge each field is taken on. Strobes made with the chip select high, or with both data strobes moved together, must leave the registers unchanged.

// File: rtl/hpiPkg.sv
package hpiPkg;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA_FIX = 2'b11
  } regSel_e;

  typedef enum logic [1:0] {
    FETCH_IDLE = 2'b00,
    FETCH_REQ  = 2'b01,
    FETCH_LOAD = 2'b10
  } fetchState_e;

  // strobes from control to datapath, valid for one clock each
  typedef struct packed {
    logic    wrEn;      // write half of selected register with hdIn
    regSel_e sel;       // register picked at the strobe fall
    logic    half;      // 0 = bits 15:0, 1 = bits 31:16
    logic    commit;    // write the full data word into memory
    logic    incAddr;   // advance address by one word
    logic    memRd;     // issue memory read at current address
    logic    loadData;  // copy memory read word into data register
    logic    capture;   // refresh the read output holding register
  } dpStrobe_t;

  // both data codes have bit 0 set
  function automatic logic isDataSel(input logic [1:0] s);
    return s[0];
  endfunction

endpackage

// File: rtl/hpiWordRam.sv
module hpiWordRam #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wAddr,
  input  logic [WIDTH-1:0] wData,
  input  logic             re,
  input  logic [AW-1:0]    rAddr,
  output logic [WIDTH-1:0] rData
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wAddr] <= wData;
  end

  always_ff @(posedge clk) begin
    if (re) rData <= store[rAddr];
  end

endmodule

// File: rtl/hpiControl.sv
module hpiControl
  import hpiPkg::*;
#(
  parameter int HOLD_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hcsN,
  input  logic       hds1,
  input  logic       hds2,
  input  logic [1:0] hcntl,
  input  logic       hhwil,
  input  logic       hrw,
  output dpStrobe_t  strb,
  output logic       hostReady,
  output logic       hdOe
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic        strobeN;
  logic        strobePrevN;
  logic        csPrevN;
  logic        accActive;
  regSel_e     latSel;
  logic        latHalf;
  logic        latRd;
  logic        dataValid;
  fetchState_e fState;
  logic [HW-1:0] holdCnt;

  logic fallEv, riseEv, rdDone;
  logic csTrig, halfTrig, autoTrig, fetchGo;

  // active-low internal strobe
  assign strobeN = ~(hds1 ^ hds2) | hcsN;

  assign fallEv   = strobePrevN & ~strobeN;
  assign riseEv   = ~strobePrevN & strobeN & accActive;
  assign rdDone   = riseEv & latRd;
  assign csTrig   = csPrevN & ~hcsN & hrw & isDataSel(hcntl);
  assign halfTrig = fallEv & hrw & isDataSel(hcntl) & ~hhwil & ~dataValid;
  assign autoTrig = rdDone & latHalf & (latSel == SEL_DATA_INC);
  assign fetchGo  = (fState == FETCH_IDLE) & (csTrig | halfTrig | autoTrig);

  always_comb begin
    strb          = '0;
    strb.sel      = latSel;
    strb.half     = latHalf;
    strb.wrEn     = riseEv & ~latRd;
    strb.commit   = riseEv & ~latRd & isDataSel(latSel) & latHalf;
    strb.incAddr  = (strb.commit & (latSel == SEL_DATA_INC)) | autoTrig;
    strb.memRd    = (fState == FETCH_REQ);
    strb.loadData = (fState == FETCH_LOAD);
    strb.capture  = accActive & latRd & ~strobeN;
  end

  assign hostReady = (fState == FETCH_IDLE);
  assign hdOe      = (holdCnt != '0);

  // edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrevN <= 1'b1;
      csPrevN     <= 1'b1;
    end else begin
      strobePrevN <= strobeN;
      csPrevN     <= hcsN;
    end
  end

  // fields latched on the strobe fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accActive <= 1'b0;
      latSel    <= SEL_CTRL;
      latHalf   <= 1'b0;
      latRd     <= 1'b0;
    end else if (fallEv) begin
      accActive <= 1'b1;
      latSel    <= regSel_e'(hcntl);
      latHalf   <= hhwil;
      latRd     <= hrw;
    end else if (riseEv) begin
      accActive <= 1'b0;
    end
  end

  // fetch sequencer: request, then load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fState <= FETCH_IDLE;
    end else begin
      unique case (fState)
        FETCH_IDLE: if (fetchGo) fState <= FETCH_REQ;
        FETCH_REQ:  fState <= FETCH_LOAD;
        FETCH_LOAD: fState <= FETCH_IDLE;
        default:    fState <= FETCH_IDLE;
      endcase
    end
  end

  // tracks whether the data register holds a fresh memory word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid <= 1'b0;
    end else if (fState == FETCH_LOAD) begin
      dataValid <= 1'b1;
    end else if (strb.wrEn && (isDataSel(latSel) || latSel == SEL_ADDR)) begin
      dataValid <= 1'b0;
    end else if (rdDone && latHalf && isDataSel(latSel)) begin
      dataValid <= 1'b0;
    end
  end

  // read output hold window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strb.capture) begin
      holdCnt <= HW'(HOLD_CYC);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  AST_FETCH_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (!hostReady && $past(!hostReady)) |=> hostReady); // R7

  AST_CS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (csTrig && hostReady) |=> !hostReady); // R7

  AST_AUTO_REFETCH: assert property (@(posedge clk) disable iff (!rstN)
    (autoTrig && hostReady) |=> !hostReady); // R9

  AST_CAPTURE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> hdOe); // R10

endmodule

// File: rtl/hpiDatapath.sv
module hpiDatapath
  import hpiPkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [15:0] hdIn,
  output logic [15:0] hdOut,
  output logic        hostInt
);

  localparam int AW = $clog2(DEPTH);
  localparam int WW = 32;

  logic [WW-1:0] ctrlReg;
  logic [WW-1:0] addrReg;
  logic [WW-1:0] dataReg;
  logic [WW-1:0] ramQ;
  logic [WW-1:0] selWord;
  logic [15:0]   selHalf;
  logic [15:0]   outReg;

  hpiWordRam #(
    .DEPTH(DEPTH),
    .WIDTH(WW),
    .AW   (AW)
  ) uRam (
    .clk  (clk),
    .we   (strb.commit),
    .wAddr(addrReg[AW-1:0]),
    .wData({hdIn, dataReg[15:0]}),
    .re   (strb.memRd),
    .rAddr(addrReg[AW-1:0]),
    .rData(ramQ)
  );

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strb.wrEn && strb.sel == SEL_CTRL) begin
      if (strb.half) ctrlReg[31:16] <= hdIn;
      else           ctrlReg[15:0]  <= hdIn;
    end
  end

  // address register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strb.wrEn && strb.sel == SEL_ADDR) begin
      if (strb.half) addrReg[31:16] <= hdIn;
      else           addrReg[15:0]  <= hdIn;
    end else if (strb.incAddr) begin
      addrReg <= addrReg + 32'd1;
    end
  end

  // data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.loadData) begin
      dataReg <= ramQ;
    end else if (strb.wrEn && isDataSel(strb.sel)) begin
      if (strb.half) dataReg[31:16] <= hdIn;
      else           dataReg[15:0]  <= hdIn;
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_CTRL: selWord = ctrlReg;
      SEL_ADDR: selWord = addrReg;
      default:  selWord = dataReg;
    endcase
    selHalf = strb.half ? selWord[31:16] : selWord[15:0];
  end

  // read output holding register, frozen once the strobe releases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outReg <= '0;
    else if (strb.capture) outReg <= selHalf;
  end

  assign hdOut   = outReg;
  assign hostInt = ctrlReg[0];

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.incAddr |=> addrReg == $past(addrReg) + 32'd1); // R6

  AST_COMMIT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> dataReg[31:16] == $past(hdIn)); // R5

endmodule

// File: rtl/hpiTarget.sv
module hpiTarget
  import hpiPkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int HOLD_CYC = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hcsN,
  input  logic        hds1,
  input  logic        hds2,
  input  logic [1:0]  hcntl,
  input  logic        hhwil,
  input  logic        hrw,
  input  logic [15:0] hdIn,
  output logic [15:0] hdOut,
  output logic        hdOe,
  output logic        hostReady,
  output logic        hostInt
);

  dpStrobe_t strb;

  hpiControl #(
    .HOLD_CYC(HOLD_CYC)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .hcsN     (hcsN),
    .hds1     (hds1),
    .hds2     (hds2),
    .hcntl    (hcntl),
    .hhwil    (hhwil),
    .hrw      (hrw),
    .strb     (strb),
    .hostReady(hostReady),
    .hdOe     (hdOe)
  );

  hpiDatapath #(
    .DEPTH(DEPTH)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .hdIn   (hdIn),
    .hdOut  (hdOut),
    .hostInt(hostInt)
  );

endmodule

// File: tb/tb_hpiTarget.sv
module tb_hpiTarget;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hcsN, hds1, hds2, hhwil, hrw;
  logic [1:0]  hcntl;
  logic [15:0] hdIn;
  logic [15:0] hdOut;
  logic        hdOe, hostReady, hostInt;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic [31:0] modelMem [64];
  logic [31:0] modelCtrl = '0;
  logic [31:0] modelAddr = '0;

  always #2 clk = ~clk;

  hpiTarget dut (
    .clk(clk), .rstN(rstN), .hcsN(hcsN), .hds1(hds1), .hds2(hds2),
    .hcntl(hcntl), .hhwil(hhwil), .hrw(hrw), .hdIn(hdIn),
    .hdOut(hdOut), .hdOe(hdOe), .hostReady(hostReady), .hostInt(hostInt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // every clock: interrupt pin tracks control bit 0 (R11)
  always begin
    @(posedge clk);
    #1;
    if (rstN === 1'b1 && !done) chk("R11 hostInt per cycle", {31'b0, hostInt}, {31'b0, modelCtrl[0]});
  end

  task automatic halfOp(input logic [1:0] c, input logic h, input logic rd,
                        input logic [15:0] wd, input bit noWait,
                        output logic [15:0] rdv, output logic rdyAfter);
    bit sawWait;
    hcntl = c; hhwil = h; hrw = rd; hdIn = wd;
    cyc();
    hds2 = 1'b0;
    cyc();
    sawWait = 1'b0;
    for (int n = 0; n < 40 && !hostReady; n++) begin
      sawWait = 1'b1;
      cyc();
    end
    cyc();
    if (!hostReady) sawWait = 1'b1;
    cyc();
    rdv = hdOut;
    if (noWait) chk("R8 second half no wait", {31'b0, sawWait}, 32'd0);
    if (!rd && c == 2'b00) begin
      if (h) modelCtrl[31:16] = wd;
      else   modelCtrl[15:0]  = wd;
    end
    hds2 = 1'b1;
    cyc();
    rdyAfter = hostReady;
  endtask

  task automatic writeWord(input logic [1:0] c, input logic [31:0] w);
    logic [15:0] d; logic r;
    halfOp(c, 1'b0, 1'b0, w[15:0], 1'b0, d, r);
    halfOp(c, 1'b1, 1'b0, w[31:16], 1'b1, d, r);
  endtask

  task automatic readWord(input logic [1:0] c, output logic [31:0] w, output logic rdy);
    logic [15:0] lo, hi; logic r;
    halfOp(c, 1'b0, 1'b1, 16'h0, 1'b0, lo, r);
    halfOp(c, 1'b1, 1'b1, 16'h0, 1'b1, hi, rdy);
    w = {hi, lo};
  endtask

  task automatic setAddr(input logic [31:0] a);
    writeWord(2'b10, a);
    modelAddr = a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [15:0] v, hv;
    logic r;

    rstN = 1'b0; hcsN = 1'b1; hds1 = 1'b1; hds2 = 1'b1;
    hcntl = 2'b00; hhwil = 1'b0; hrw = 1'b0; hdIn = '0;
    repeat (5) cyc();
    rstN = 1'b1;
    cyc();

    // R12 reset state
    chk("R12 hostReady", {31'b0, hostReady}, 32'd1);
    chk("R12 hdOe", {31'b0, hdOe}, 32'd0);
    chk("R12 hostInt", {31'b0, hostInt}, 32'd0);
    hcsN = 1'b0;
    cyc();
    readWord(2'b00, w, r); chk("R12 control reads zero", w, 32'd0);
    readWord(2'b10, w, r); chk("R12 address reads zero", w, 32'd0);

    // R4 / R11 register select and halves
    writeWord(2'b00, 32'hA5A5_0001);
    chk("R11 hostInt set", {31'b0, hostInt}, 32'd1);
    readWord(2'b00, w, r); chk("R4 control readback", w, 32'hA5A5_0001);
    writeWord(2'b10, 32'h1234_0007);
    halfOp(2'b10, 1'b0, 1'b1, 16'h0, 1'b0, v, r); chk("R4 address low half", {16'b0, v}, 32'h0007);
    halfOp(2'b10, 1'b1, 1'b1, 16'h0, 1'b1, v, r); chk("R4 address high half", {16'b0, v}, 32'h1234);
    writeWord(2'b00, 32'h0000_5A5A);
    chk("R11 hostInt clear", {31'b0, hostInt}, 32'd0);

    // R5 / R6 fixed-address write, lone first half
    setAddr(32'd5);
    writeWord(2'b11, 32'hDEAD_BEEF); modelMem[5] = 32'hDEAD_BEEF;
    readWord(2'b10, w, r); chk("R6 fixed write keeps address", w, 32'd5);
    halfOp(2'b11, 1'b0, 1'b0, 16'h1111, 1'b0, v, r);
    readWord(2'b11, w, r); chk("R5 lone first half not committed", w, modelMem[5]);

    // R6 auto-increment write burst
    setAddr(32'd8);
    for (int i = 0; i < 4; i++) begin
      w = 32'hC0DE_0000 + 32'(i * 17 + 3);
      writeWord(2'b01, w);
      modelMem[8 + i] = w;
    end
    readWord(2'b10, w, r); chk("R6 address after four words", w, 32'd12);

    // R7 chip-select fall with read intent
    setAddr(32'd9);
    hcsN = 1'b1; hcntl = 2'b11; hrw = 1'b1; hhwil = 1'b0;
    cyc();
    chk("R7 ready before select", {31'b0, hostReady}, 32'd1);
    hcsN = 1'b0;
    cyc(); chk("R7 wait cycle 1", {31'b0, hostReady}, 32'd0);
    cyc(); chk("R7 wait cycle 2", {31'b0, hostReady}, 32'd0);
    cyc(); chk("R7 ready after fetch", {31'b0, hostReady}, 32'd1);
    readWord(2'b11, w, r); chk("R7 fetched word", w, modelMem[9]);

    // R9 auto-increment read with prefetch
    setAddr(32'd8);
    for (int i = 0; i < 4; i++) begin
      readWord(2'b01, w, r);
      chk("R9 sequential word", w, modelMem[8 + i]);
      chk("R9 prefetch wait after second half", {31'b0, r}, 32'd0);
    end
    readWord(2'b10, w, r); chk("R9 address advanced", w, 32'd12);

    // R10 output hold after release
    hcntl = 2'b00; hhwil = 1'b0; hrw = 1'b1;
    cyc();
    hds2 = 1'b0;
    cyc(); cyc(); cyc();
    v = hdOut;
    chk("R10 drive during strobe", {31'b0, hdOe}, 32'd1);
    chk("R10 value during strobe", {16'b0, v}, 32'h5A5A);
    hds2 = 1'b1;
    cyc(); chk("R10 hold 1 enable", {31'b0, hdOe}, 32'd1);
    chk("R10 hold 1 value", {16'b0, hdOut}, {16'b0, v});
    cyc(); chk("R10 hold 2 enable", {31'b0, hdOe}, 32'd1);
    chk("R10 hold 2 value", {16'b0, hdOut}, {16'b0, v});
    cyc(); chk("R10 released", {31'b0, hdOe}, 32'd0);

    // R1 strobe formation
    setAddr(32'd3);
    hcsN = 1'b1; hcntl = 2'b10; hhwil = 1'b0; hrw = 1'b0; hdIn = 16'h00FF;
    cyc();
    hds2 = 1'b0; cyc(); cyc(); hds2 = 1'b1; cyc();
    hcsN = 1'b0; cyc();
    hds1 = 1'b0; hds2 = 1'b0; cyc(); cyc();
    hds1 = 1'b1; hds2 = 1'b1; cyc();
    readWord(2'b10, w, r); chk("R1 no access without select or equal strobes", w, 32'd3);
    hcntl = 2'b10; hhwil = 1'b0; hrw = 1'b0; hdIn = 16'h0004;
    cyc();
    hds1 = 1'b0; cyc(); cyc(); hds1 = 1'b1; cyc();
    readWord(2'b10, w, r); chk("R1 first strobe alone accesses", w, 32'd4);

    // R2 / R3 field and data sampling edges
    hcntl = 2'b10; hhwil = 1'b0; hrw = 1'b0; hdIn = 16'h0AAA;
    cyc();
    hds2 = 1'b0; cyc(); cyc();
    hcntl = 2'b00; hhwil = 1'b1; hrw = 1'b1; hdIn = 16'h0021;
    cyc();
    hds2 = 1'b1; cyc();
    readWord(2'b10, w, r);
    chk("R3 data taken at release", w, 32'h0000_0021);
    readWord(2'b00, w, r);
    chk("R2 fields taken at strobe fall", w, modelCtrl);
    halfOp(2'b00, 1'b1, 1'b1, 16'h0, 1'b1, hv, r);
    chk("R2 control high half untouched", {16'b0, hv}, {16'b0, modelCtrl[31:16]});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule